// File: doc/BRIEF.md
# Clear-on-read interrupt aggregator

This block gathers interrupt events from three places and turns them into one active-low, open-drain request line toward a host processor. The first source is a completion strobe from an analog conversion unit. The second is a completion strobe from a vector arithmetic unit. The third is a change of level, rising or falling, on any of six general-purpose pins. Each source has its own enable bit. A pin raises a change event only when it is enabled and configured as an input.

The host sets the block up through a small synchronous register bus with a 12-bit data path. A status register holds one flag per source plus a global flag. The host learns which source fired by reading that register, and the read clears the flags. The request output has two modes. In pulse mode it pulls the line low for one clock per event. In hold mode it keeps the line low until the host reads the status register, so several devices can share one wired request line. The pin is modelled as an output enable: 1 means the line is pulled low, 0 means it is released.

Top module: `irq_collector`

## Requirements
- R1: After reset, `irq_oe` is 0. Reads of the system control, pin control and status registers all return 0.
- R2: When system control bit 7 is 1, a `conv_done` high at a clock edge sets status bit 0 and status bit 11 at that edge.
- R3: When system control bit 6 is 1, an `xform_done` high at a clock edge sets status bit 1 and status bit 11 at that edge.
- R4: The pin control register uses bits 0 to 5 as direction for pins 0 to 5, where 1 means output. It uses bits 6 to 11 as change enables for pins 0 to 5. When pin k is enabled and has direction 0, a rising or falling change of `pin_in[k]` from its value at the previous edge sets status bits 2 and 11. With direction 1, the same change sets nothing.
- R5: A status read returns the flags on `rdata` in bits 0, 1, 2 and 11, with all other bits 0. After that read the flags are 0.
- R6: If an enabled event arrives in the same cycle as a status read, the read returns the old flags and the new event's flags stay set afterwards.
- R7: When system control bit 8 is 0 (pulse mode), `irq_oe` is 1 for exactly one cycle after each clock edge that saw an enabled event.
- R8: When system control bit 8 is 1 (hold mode), `irq_oe` goes to 1 after an enabled event and stays at 1 until the edge of a status read that has no new event.
- R9: An event whose enable bit is 0 sets no flag and does not assert `irq_oe`.
- R10: The register addresses are 0 for system control, 1 for pin control, 2 for status and 3 unused (reads 0). A write takes effect when `cs` and `wr` are high at an edge. Read data appears on `rdata` one cycle after `cs` and `rd`, and holds between reads. System control reads back only bits 6, 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Register bus select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | 12 | Write data |
| rdata | output | 12 | Registered read data |
| conv_done | input | 1 | End-of-conversion strobe |
| xform_done | input | 1 | End-of-transformation strobe |
| pin_in | input | 6 | General-purpose pin levels |
| irq_oe | output | 1 | Open-drain pull-down enable for the request line |

## Verification
An event sampled at edge n sets its flags at edge n and raises `irq_oe` at edge n. Both are therefore visible at the falling edge that follows, and the bench samples them there. Read data is captured at the edge where `cs` and `rd` are high and is checked half a cycle later. The flag clear from that same edge shows at the same point. A reference model in the bench steps at every rising edge and is compared against `irq_oe` and `rdata` at every falling edge. Directed checks add explicit expected values for each requirement.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DW        = 12;
    localparam int NPIO      = 6;
    localparam int AW        = 2;
    localparam int SYS_XF_EN = 6;
    localparam int SYS_CV_EN = 7;
    localparam int SYS_HOLD  = 8;
    localparam int ST_CV     = 0;
    localparam int ST_XF     = 1;
    localparam int ST_IO     = 2;
    localparam int ST_ANY    = DW - 1;

    typedef enum logic [AW-1:0] {
        A_SYS  = 2'd0,
        A_PIO  = 2'd1,
        A_STAT = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef enum logic {
        M_PULSE = 1'b0,
        M_HOLD  = 1'b1
    } req_mode_e;

    typedef struct packed {
        logic            cv_en;
        logic            xf_en;
        req_mode_e       mode;
        logic [NPIO-1:0] pin_en;
        logic [NPIO-1:0] pin_out;
    } ctrl_t;

    typedef struct packed {
        logic cv;
        logic xf;
        logic io;
    } evt_t;

    typedef struct packed {
        logic any;
        logic io;
        logic xf;
        logic cv;
    } flags_t;

    function automatic logic [DW-1:0] pack_status(flags_t f);
        logic [DW-1:0] v;
        v         = '0;
        v[ST_CV]  = f.cv;
        v[ST_XF]  = f.xf;
        v[ST_IO]  = f.io;
        v[ST_ANY] = f.any;
        return v;
    endfunction

    function automatic logic [DW-1:0] pack_sys(ctrl_t c);
        logic [DW-1:0] v;
        v            = '0;
        v[SYS_XF_EN] = c.xf_en;
        v[SYS_CV_EN] = c.cv_en;
        v[SYS_HOLD]  = c.mode;
        return v;
    endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  flags_t        flags,
    output ctrl_t         ctrl,
    output logic [DW-1:0] rdata,
    output logic          stat_rd
);
    reg_addr_e sel;
    assign sel     = reg_addr_e'(addr);
    assign stat_rd = cs && rd && (sel == A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (cs && wr) begin
            if (sel == A_SYS) begin
                ctrl.cv_en <= wdata[SYS_CV_EN];
                ctrl.xf_en <= wdata[SYS_XF_EN];
                ctrl.mode  <= req_mode_e'(wdata[SYS_HOLD]);
            end else if (sel == A_PIO) begin
                ctrl.pin_out <= wdata[NPIO-1:0];
                ctrl.pin_en  <= wdata[2*NPIO-1:NPIO];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (cs && rd) begin
            case (sel)
                A_SYS:   rdata <= pack_sys(ctrl);
                A_PIO:   rdata <= {ctrl.pin_en, ctrl.pin_out};
                A_STAT:  rdata <= pack_status(flags);
                default: rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_detect.sv
module irq_detect
    import irq_pkg::*;
#(
    parameter int N_PIN = NPIO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cv_en,
    input  logic             xf_en,
    input  logic [N_PIN-1:0] pin_en,
    input  logic [N_PIN-1:0] pin_out,
    input  logic             conv_done,
    input  logic             xform_done,
    input  logic [N_PIN-1:0] pin_in,
    output evt_t             evt
);
    logic [N_PIN-1:0] pin_q;
    logic [N_PIN-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pin_in;
    end

    for (genvar i = 0; i < N_PIN; i++) begin : g_pin
        assign hit[i] = pin_en[i] && !pin_out[i] && (pin_in[i] != pin_q[i]);
    end

    assign evt.cv = cv_en && conv_done;
    assign evt.xf = xf_en && xform_done;
    assign evt.io = |hit;
endmodule

// File: rtl/irq_flags.sv
module irq_flags
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  evt_t      evt,
    input  logic      stat_rd,
    input  req_mode_e mode,
    output flags_t    flags,
    output logic      irq_oe
);
    logic   any_ev;
    flags_t keep;

    assign any_ev = evt.cv || evt.xf || evt.io;
    assign keep   = stat_rd ? '0 : flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            irq_oe <= 1'b0;
        end else begin
            flags.cv  <= keep.cv  || evt.cv;
            flags.xf  <= keep.xf  || evt.xf;
            flags.io  <= keep.io  || evt.io;
            flags.any <= keep.any || any_ev;
            if (mode == M_HOLD) irq_oe <= any_ev || (irq_oe && !stat_rd);
            else                irq_oe <= any_ev;
        end
    end
endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs,
    input  logic            rd,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic            conv_done,
    input  logic            xform_done,
    input  logic [NPIO-1:0] pin_in,
    output logic            irq_oe
);
    ctrl_t  ctrl_w;
    evt_t   evt_w;
    flags_t flags_w;
    logic   stat_rd_w;

    irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs),
        .rd      (rd),
        .wr      (wr),
        .addr    (addr),
        .wdata   (wdata),
        .flags   (flags_w),
        .ctrl    (ctrl_w),
        .rdata   (rdata),
        .stat_rd (stat_rd_w)
    );

    irq_detect #(.N_PIN(NPIO)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .cv_en      (ctrl_w.cv_en),
        .xf_en      (ctrl_w.xf_en),
        .pin_en     (ctrl_w.pin_en),
        .pin_out    (ctrl_w.pin_out),
        .conv_done  (conv_done),
        .xform_done (xform_done),
        .pin_in     (pin_in),
        .evt        (evt_w)
    );

    irq_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_w),
        .stat_rd (stat_rd_w),
        .mode    (ctrl_w.mode),
        .flags   (flags_w),
        .irq_oe  (irq_oe)
    );
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk
    import irq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          cs,
    input logic          rd,
    input logic          irq_oe,
    input logic [DW-1:0] rdata,
    input logic          stat_rd,
    input evt_t          evt,
    input flags_t        flags,
    input ctrl_t         ctrl
);
    logic any_ev;
    assign any_ev = evt.cv || evt.xf || evt.io;

    assert_global_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (flags.cv || flags.xf || flags.io) |-> flags.any);

    assert_out_pin_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (&ctrl.pin_out) |-> !evt.io);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !any_ev) |=> (flags == '0));

    assert_event_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && evt.cv) |=> flags.cv);

    assert_pulse_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == M_PULSE && !any_ev) |=> !irq_oe);

    assert_hold_stays_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == M_HOLD && irq_oe && !stat_rd) |=> irq_oe);

    assert_disabled_src_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.cv_en && !ctrl.xf_en && ctrl.pin_en == '0) |-> !any_ev);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(cs && rd) |=> $stable(rdata));
endmodule

bind irq_collector irq_collector_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .rd      (rd),
    .irq_oe  (irq_oe),
    .rdata   (rdata),
    .stat_rd (stat_rd_w),
    .evt     (evt_w),
    .flags   (flags_w),
    .ctrl    (ctrl_w)
);

// File: tb/test_irq_collector.sv
module test_irq_collector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [11:0] wdata = 12'd0;
    logic [11:0] rdata;
    logic        conv_done = 1'b0, xform_done = 1'b0;
    logic [5:0]  pin_in = 6'd0;
    logic        irq_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [11:0] m_sys, m_pio, m_rdata;
    logic [3:0]  m_fl;    // {any, io, xf, cv}
    logic        m_oe;
    logic [5:0]  m_pin;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_collector i_irq_collector (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .conv_done(conv_done),
        .xform_done(xform_done), .pin_in(pin_in), .irq_oe(irq_oe)
    );

    always @(posedge clk) begin
        bit ec, ex, ep, any, srd;
        logic [3:0] nf;
        if (rst) begin
            m_sys = 0; m_pio = 0; m_rdata = 0; m_fl = 0; m_oe = 0; m_pin = 0;
        end else begin
            ec = conv_done && m_sys[7];
            ex = xform_done && m_sys[6];
            ep = 0;
            for (int k = 0; k < 6; k++)
                if (m_pio[6+k] && !m_pio[k] && pin_in[k] != m_pin[k]) ep = 1;
            any = ec || ex || ep;
            srd = cs && rd && addr == 2'd2;
            if (cs && rd) begin
                case (addr)
                    2'd0: m_rdata = m_sys & 12'h1C0;
                    2'd1: m_rdata = m_pio;
                    2'd2: m_rdata = {m_fl[3], 8'd0, m_fl[2:0]};
                    default: m_rdata = 0;
                endcase
            end
            nf = srd ? 4'd0 : m_fl;
            nf = nf | {any, ep, ex, ec};
            m_fl = nf;
            m_oe = m_sys[8] ? (any || (m_oe && !srd)) : any;
            if (cs && wr) begin
                if (addr == 2'd0) m_sys = wdata & 12'h1C0;
                else if (addr == 2'd1) m_pio = wdata;
            end
            m_pin = pin_in;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            total++;
            if (irq_oe !== m_oe) begin
                bad++;
                $display("FAIL R7,R8 model irq_oe actual=%0b expected=%0b t=%0t", irq_oe, m_oe, $time);
            end
            total++;
            if (rdata !== m_rdata) begin
                bad++;
                $display("FAIL R10 model rdata actual=%h expected=%h t=%0t", rdata, m_rdata, $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [11:0] d);
        @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; wr = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, input bit with_xf, output logic [11:0] v);
        @(negedge clk); cs = 1; rd = 1; addr = a; xform_done = with_xf;
        @(negedge clk); cs = 0; rd = 0; xform_done = 0; v = rdata;
    endtask

    task automatic pulse_conv();
        @(negedge clk); conv_done = 1;
        @(negedge clk); conv_done = 0;
    endtask

    task automatic pulse_xf();
        @(negedge clk); xform_done = 1;
        @(negedge clk); xform_done = 0;
    endtask

    task automatic set_pins(input logic [5:0] p);
        @(negedge clk); pin_in = p;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [11:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 irq_oe after reset", {11'd0, irq_oe}, 12'd0);
        rd_reg(2'd0, 0, v); chk("R1 sys ctrl reset", v, 12'h000);
        rd_reg(2'd1, 0, v); chk("R1 pin ctrl reset", v, 12'h000);
        rd_reg(2'd2, 0, v); chk("R1 status reset", v, 12'h000);

        pulse_conv();
        chk("R9 disabled conv no irq", {11'd0, irq_oe}, 12'd0);
        rd_reg(2'd2, 0, v); chk("R9 disabled conv no flag", v, 12'h000);

        wr_reg(2'd0, 12'h080);
        pulse_conv();
        chk("R7 pulse high", {11'd0, irq_oe}, 12'd1);
        @(negedge clk);
        chk("R7 pulse one cycle", {11'd0, irq_oe}, 12'd0);
        rd_reg(2'd2, 0, v); chk("R2 conv flags", v, 12'h801);
        rd_reg(2'd2, 0, v); chk("R5 cleared after read", v, 12'h000);

        wr_reg(2'd0, 12'h040);
        pulse_conv();
        pulse_xf();
        rd_reg(2'd2, 0, v); chk("R3 xform flags only", v, 12'h802);

        wr_reg(2'd1, 12'h040);
        set_pins(6'h01);
        rd_reg(2'd2, 0, v); chk("R4 rising change", v, 12'h804);
        set_pins(6'h00);
        rd_reg(2'd2, 0, v); chk("R4 falling change", v, 12'h804);
        wr_reg(2'd1, 12'h041);
        set_pins(6'h01);
        rd_reg(2'd2, 0, v); chk("R4 output pin ignored", v, 12'h000);
        set_pins(6'h02);
        rd_reg(2'd2, 0, v); chk("R9 pin1 not enabled", v, 12'h000);
        wr_reg(2'd1, 12'h800);
        set_pins(6'h22);
        rd_reg(2'd2, 0, v); chk("R4 pin5 change", v, 12'h804);

        wr_reg(2'd0, 12'h1C0);
        rd_reg(2'd0, 0, v); chk("R10 sys readback", v, 12'h1C0);
        pulse_conv();
        chk("R8 hold asserted", {11'd0, irq_oe}, 12'd1);
        repeat (3) @(negedge clk);
        chk("R8 hold stays", {11'd0, irq_oe}, 12'd1);
        rd_reg(2'd2, 0, v);
        chk("R5 status in hold mode", v, 12'h801);
        chk("R8 released by read", {11'd0, irq_oe}, 12'd0);

        pulse_conv();
        rd_reg(2'd2, 1, v);
        chk("R6 read returns old flags", v, 12'h801);
        chk("R6 irq held by new event", {11'd0, irq_oe}, 12'd1);
        rd_reg(2'd2, 0, v);
        chk("R6 new event kept", v, 12'h802);
        chk("R8 released after second read", {11'd0, irq_oe}, 12'd0);

        rd_reg(2'd3, 0, v); chk("R10 unused address", v, 12'h000);
        rd_reg(2'd1, 0, v); chk("R10 pin ctrl readback", v, 12'h800);

        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule